// File: doc/BRIEF.md
# Delay Tap Command Port

This block sits between a host register file and the delay taps of an SD/eMMC PHY. Software reaches the tap settings through one 32-bit command word. It loads an 8-bit tap address and 8-bit data into the word, then raises a write strobe or a read strobe. The block carries out the tap access and raises an acknowledge flag in the same word. A read returns the tap value in a field of the word.

An access is a sequence of whole-word writes. First the address and data go in with both strobes low. Then the same word is written again with one strobe set. Last, the strobe is cleared. Only the rising edge of a strobe starts an access, so holding a strobe high repeats nothing.

The bank holds nine tap entries, one for each bus timing class: SD high speed, SD default, three UHS single-rate speeds, UHS double rate, eMMC legacy, eMMC single rate and eMMC double rate. All entries are also driven out together in parallel to the delay lines.

Top module: `phy_dly_port`

## Requirements
- R1: Reading the command word returns the stored address in bits [7:0], the stored write data in bits [15:8], the write strobe in bit 24, the read strobe in bit 25 and the acknowledge in bit 26. Bits [31:27] read as zero.
- R2: The write data is committed to the addressed entry when bit 24 goes from 0 to 1. Entry k appears on `dly_taps[k*8 +: 8]`.
- R3: While the write strobe stays high, no further commit takes place, even if the word is rewritten with new data.
- R4: When bit 25 goes from 0 to 1, the addressed entry is captured into bits [23:16]. The captured value stays there until the next read strobe edge.
- R5: The acknowledge bit is 0 in the cycle in which a rising strobe edge is first visible. It is 1 in the next cycle.
- R6: The acknowledge stays 1 while either strobe is high. It returns to 0 one cycle after both strobes are seen low.
- R7: Writes to addresses 0x09 and above change no entry. Reads from those addresses return 0 in bits [23:16].
- R8: Reset clears every entry, every command field and the acknowledge.
- R9: Addresses 0x00 to 0x08 each select a separate entry. Writing 4, 4, 9, 2 and 3 to addresses 0, 1, 6, 7 and 8 leaves exactly those values on the tap outputs and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write enable for the command word |
| cmd_wdata | input | 32 | Command word written by software |
| cmd_rdata | output | 32 | Command word read back, with read data and acknowledge |
| dly_taps | output | 72 | All tap entries, entry k at bits [k*8 +: 8] |

## Verification
The assertions assume that software never raises both strobes in the same word. They also assume that every access returns its strobe to low before the next access begins, so each acknowledge belongs to exactly one edge. The stimulus keeps to this. Every read and write goes through the three-step sequence, with idle cycles after each step. The only case where a strobe is held high across a rewrite is the deliberate R3 check, and there the other strobe stays low.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;
   localparam int unsigned CMD_W     = 32;
   localparam int unsigned FLD_W     = 8;
   localparam int unsigned ADDR_LSB  = 0;
   localparam int unsigned WDAT_LSB  = 8;
   localparam int unsigned RDAT_LSB  = 16;
   localparam int unsigned WSTB_BIT  = 24;
   localparam int unsigned RSTB_BIT  = 25;
   localparam int unsigned ACK_BIT   = 26;
endpackage

// File: rtl/phy_dly_cmd.sv
module phy_dly_cmd
   import phy_dly_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   output logic [FLD_W-1:0] addr,
   output logic [FLD_W-1:0] wdata,
   output logic             wr_stb,
   output logic             rd_stb,
   output logic             wr_rise,
   output logic             rd_rise
);
   logic wr_d1, rd_d1;
   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd_wdata[CMD_W-1:RSTB_BIT+1], cmd_wdata[RDAT_LSB +: FLD_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         wdata  <= '0;
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         wr_d1  <= 1'b0;
         rd_d1  <= 1'b0;
      end else begin
         if (cmd_wr) begin
            addr   <= cmd_wdata[ADDR_LSB +: FLD_W];
            wdata  <= cmd_wdata[WDAT_LSB +: FLD_W];
            wr_stb <= cmd_wdata[WSTB_BIT];
            rd_stb <= cmd_wdata[RSTB_BIT];
         end
         wr_d1 <= wr_stb;
         rd_d1 <= rd_stb;
      end
   end

   assign wr_rise = wr_stb & ~wr_d1;
   assign rd_rise = rd_stb & ~rd_d1;

   // a rising edge lasts exactly one cycle (R3)
   assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |=> !wr_rise);
endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
   import phy_dly_pkg::*;
#(
   parameter int unsigned N_ENT = 9,
   parameter int unsigned DLY_W = 8
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [FLD_W-1:0]       addr,
   input  logic [FLD_W-1:0]       wdata,
   input  logic                   wr_en,
   input  logic                   rd_en,
   output logic [FLD_W-1:0]       rdata,
   output logic [N_ENT*DLY_W-1:0] dly_taps
);
   localparam int unsigned TAPS_W = N_ENT * DLY_W;

   generate
      if (N_ENT == 0 || N_ENT > (1 << FLD_W)) begin : g_bad_depth
         $error("phy_dly_bank: N_ENT out of range");
      end
      if (DLY_W == 0 || DLY_W > FLD_W) begin : g_bad_width
         $error("phy_dly_bank: DLY_W out of range");
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < N_ENT; k++) begin : g_ent
         logic [DLY_W-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent_q <= '0;
            else if (wr_en && addr == FLD_W'(k))
               ent_q <= wdata[DLY_W-1:0];
         end
         assign dly_taps[k*DLY_W +: DLY_W] = ent_q;
      end
   endgenerate

   logic [DLY_W-1:0] sel;
   always_comb begin
      sel = '0;
      for (int i = 0; i < N_ENT; i++)
         if (addr == FLD_W'(i)) sel = dly_taps[i*DLY_W +: DLY_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= FLD_W'(sel);
   end

   assert_hold_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(dly_taps));
   assert_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) >= int'(N_ENT)) |=> $stable(dly_taps));
   assert_oob_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && int'(addr) >= int'(N_ENT)) |=> (rdata == '0));
   assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   logic unused_taps_w;
   assign unused_taps_w = (TAPS_W == 0);
endmodule

// File: rtl/phy_dly_ack.sv
module phy_dly_ack (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_rise,
   input  logic rd_rise,
   input  logic wr_stb,
   input  logic rd_stb,
   output logic ack
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         ack <= 1'b0;
      else if (wr_rise || rd_rise)
         ack <= 1'b1;
      else if (!wr_stb && !rd_stb)
         ack <= 1'b0;
   end

   assert_ack_follows_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise || rd_rise) |=> ack);
   assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !rd_stb) |=> !ack);
   assert_ack_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (wr_stb || rd_stb)) |=> ack);
endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
   import phy_dly_pkg::*;
#(
   parameter int unsigned N_ENT = 9,
   parameter int unsigned DLY_W = 8
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_wr,
   input  logic [31:0]            cmd_wdata,
   output logic [31:0]            cmd_rdata,
   output logic [N_ENT*DLY_W-1:0] dly_taps
);
   logic [FLD_W-1:0] addr, wdata, rdata;
   logic wr_stb, rd_stb, wr_rise, rd_rise, ack;

   phy_dly_cmd u_cmd (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .addr(addr), .wdata(wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .wr_rise(wr_rise), .rd_rise(rd_rise)
   );

   phy_dly_bank #(.N_ENT(N_ENT), .DLY_W(DLY_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_rise), .rd_en(rd_rise), .rdata(rdata), .dly_taps(dly_taps)
   );

   phy_dly_ack u_ack (
      .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .rd_rise(rd_rise),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .ack(ack)
   );

   always_comb begin
      cmd_rdata = '0;
      cmd_rdata[ADDR_LSB +: FLD_W] = addr;
      cmd_rdata[WDAT_LSB +: FLD_W] = wdata;
      cmd_rdata[RDAT_LSB +: FLD_W] = rdata;
      cmd_rdata[WSTB_BIT] = wr_stb;
      cmd_rdata[RSTB_BIT] = rd_stb;
      cmd_rdata[ACK_BIT]  = ack;
   end

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (cmd_rdata == '0 && dly_taps == '0));
endmodule

// File: tb/sim_phy_dly_port.sv
module sim_phy_dly_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] cmd_rdata;
   logic [71:0] dly_taps;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   logic [7:0] model [9];
   logic [7:0] rd_q [$];

   always #2.5 clk = ~clk;

   phy_dly_port u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .dly_taps(dly_taps)
   );

   task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_cmd(input logic [31:0] v);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_wdata = v;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   function automatic logic [71:0] model_taps();
      logic [71:0] t;
      for (int i = 0; i < 9; i++) t[i*8 +: 8] = model[i];
      return t;
   endfunction

   task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
      logic [31:0] w;
      w = {16'h0, d, a};
      put_cmd(w);
      put_cmd(w | 32'h0100_0000);
      check(cmd_rdata[26] == 1'b0, "R5 ack low in edge cycle", cmd_rdata[26], 0);
      @(negedge clk);
      check(cmd_rdata[26] == 1'b1, "R5 ack one cycle after write edge", cmd_rdata[26], 1);
      if (a < 8'd9) model[a] = d;
      put_cmd(w);
      @(negedge clk);
      check(cmd_rdata[26] == 1'b0, "R6 ack cleared after strobes low", cmd_rdata[26], 0);
   endtask

   task automatic phy_read(input logic [7:0] a);
      rd_q.push_back(a < 8'd9 ? model[a] : 8'h00);
      put_cmd({24'h0, a});
      put_cmd({24'h0, a} | 32'h0200_0000);
      @(negedge clk);
      @(negedge clk);
      put_cmd({24'h0, a});
      @(negedge clk);
   endtask

   // scoreboard monitor: pops one expected value per read acknowledge
   logic prev_ack = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_rdata[26] && !prev_ack && cmd_rdata[25]) begin
            if (rd_q.size() == 0)
               check(1'b0, "R4 unexpected read ack", cmd_rdata, 0);
            else
               check(cmd_rdata[23:16] == rd_q[0], "R4/R7 read data", cmd_rdata[23:16], rd_q[0]);
            if (rd_q.size() != 0) void'(rd_q.pop_front());
         end
         prev_ack <= cmd_rdata[26];
      end else begin
         prev_ack <= 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [71:0] snap;
      for (int i = 0; i < 9; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_rdata == 32'h0, "R8 command word after reset", cmd_rdata, 0);
      check(dly_taps == 72'h0, "R8 taps after reset", dly_taps, 0);

      put_cmd(32'hFFFF_5A03 & 32'h00FF_FFFF);
      check(cmd_rdata == 32'h0000_5A03, "R1 field layout", cmd_rdata, 32'h0000_5A03);
      put_cmd(32'h0);

      phy_write(8'h00, 8'd4);
      phy_write(8'h01, 8'd4);
      phy_write(8'h06, 8'd9);
      phy_write(8'h07, 8'd2);
      phy_write(8'h08, 8'd3);
      check(dly_taps == model_taps(), "R9 init pattern on taps", dly_taps, model_taps());
      check(dly_taps == 72'h03_02_09_00_00_00_00_04_04, "R2 entry positions", dly_taps,
            72'h03_02_09_00_00_00_00_04_04);

      for (int i = 0; i < 9; i++) phy_read(8'(i));
      phy_write(8'h03, 8'hA5);
      phy_read(8'h03);
      check(dly_taps[31:24] == 8'hA5, "R2 entry 3 written", dly_taps[31:24], 8'hA5);

      // R3: strobe held high while data changes
      put_cmd(32'h0000_1102);
      put_cmd(32'h0100_1102);
      repeat (2) @(negedge clk);
      put_cmd(32'h0100_2202);
      repeat (3) @(negedge clk);
      check(dly_taps[23:16] == 8'h11, "R3 no second commit", dly_taps[23:16], 8'h11);
      check(cmd_rdata[26] == 1'b1, "R6 ack held while strobe high", cmd_rdata[26], 1);
      put_cmd(32'h0000_2202);
      @(negedge clk);
      check(cmd_rdata[26] == 1'b0, "R6 ack dropped", cmd_rdata[26], 0);
      model[2] = 8'h11;

      // R7: out-of-range accesses
      snap = dly_taps;
      phy_write(8'h09, 8'hFF);
      phy_write(8'hFF, 8'h77);
      check(dly_taps == snap, "R7 out-of-range write ignored", dly_taps, snap);
      phy_read(8'h09);
      phy_read(8'hC0);
      phy_read(8'h02);

      check(rd_q.size() == 0, "R4 all reads acknowledged", rd_q.size(), 0);

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(dly_taps == 72'h0 && cmd_rdata == 32'h0, "R8 reset clears taps", dly_taps, 0);
      rst_n = 1'b1;

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule